// File: doc/BRIEF.md
# Streamed Word Port for Byte Buffer Memories

This block gives a microprocessor access to two byte-organised buffer memories through one 16-bit data port. One memory carries isochronous traffic and is split into two ping-pong halves. The other carries asynchronous traffic. The processor first programs a transfer length and issues a single one-byte command that names the memory and the direction. It then makes as many 16-bit data-port accesses as the transfer needs. Each access moves two adjacent bytes: the low port byte is the even address and the high port byte is the odd address that follows it. An internal byte pointer advances by two on every access.

When the pointer reaches the programmed length, the transfer closes by itself. The block raises an end-of-transfer event, latches an interrupt status bit and updates the buffer status flags. A start-of-frame tick swaps which isochronous half the processor works on. The swap is held off while both halves are marked full, and in that case the processor stays on half 1. The engine that drains the buffers reports through per-half drain-done pulses.

Top module: `bufport_top`

## Requirements
- R1: Command codes decode as follows: bit 7 is the direction (1 = write, 0 = read) and bit 0 is the target (1 = asynchronous, 0 = isochronous). The valid codes are 0x40, 0xC0, 0x41 and 0xC1. Any other code on `cmd_stb` is ignored, and a transfer already in progress continues unchanged.
- R2: Words written through the port during a write transfer read back unchanged, in the same order, during a later read transfer of the same memory from pointer zero.
- R3: After one command, each accepted data access moves the next two bytes, so consecutive reads return consecutive stored words.
- R4: The length written on `cnt_wr` is a byte count rounded up to an even value. The transfer ends on the access that brings the pointer equal to that value.
- R5: End of transfer sets `int_status[2]`. Writing a 1 to bit 2 on `stat_clr_wr` clears it, and writing 0 there leaves it set.
- R6: Data accesses are ignored when no transfer is active, after end of transfer, or when `data_we` disagrees with the command direction. Ignored accesses change no memory, do not advance the pointer, and read 0.
- R7: The end of a write transfer into an isochronous half sets that half's bit in `iso_full`. Read transfers do not set it. A `drain_done` pulse for a half clears that half's bit.
- R8: A `sof` pulse toggles `iso_sel` unless both `iso_full` bits are 1, in which case `iso_sel` becomes 1. A transfer uses the half that was selected when its command was issued.
- R9: `async_done` is set at the end of an asynchronous transfer and cleared by the next valid command.
- R10: Every valid command resets the byte pointer to zero.
- R11: After reset, `iso_sel`, `iso_full`, `async_done` and `int_status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cnt_wr | input | 1 | Transfer length write strobe |
| cnt_val | input | 16 | Transfer length in bytes |
| data_stb | input | 1 | Data port access strobe |
| data_we | input | 1 | Data access is a write |
| wdata | input | 16 | Write data, low byte to even address |
| rdata | output | 16 | Read data, valid while a read access is accepted |
| stat_clr_wr | input | 1 | Interrupt status write strobe |
| stat_clr_data | input | 8 | Write-one-to-clear mask for int_status |
| sof | input | 1 | Start-of-frame tick |
| drain_done | input | 2 | Per-half isochronous drain-done pulses |
| iso_sel | output | 1 | Isochronous half currently seen by the processor |
| iso_full | output | 2 | Per-half isochronous full flags |
| async_done | output | 1 | Asynchronous transfer completed |
| int_status | output | 8 | Interrupt status, bit 2 is end of transfer |

## Verification
The hardest state to reach is both isochronous halves full at the same time. That requires two complete write transfers separated by a frame tick, and no drain in between. Only from that state can the held-off swap be observed, followed by its release once one half drains. The stimulus fills half 0, ticks, fills half 1, ticks twice while both are full, drains half 1 and ticks again. Each half is then read back to confirm that the two writes landed in separate halves. Ignored accesses are confirmed by reading later whether the stored data survived a stray write.

// File: rtl/bufport_pkg.sv
package bufport_pkg;
   localparam int EOT_BIT = 2;

   typedef struct packed {
      logic valid;
      logic wr;
      logic asy;
   } op_t;

   function automatic op_t decode_op(input logic [7:0] code);
      op_t o;
      o.valid = code[6] && (code[5:1] == 5'b0);
      o.wr    = code[7];
      o.asy   = code[0];
      return o;
   endfunction
endpackage

// File: rtl/bufport_mem.sv
module bufport_mem #(
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-2:0] waddr,
   input  logic [15:0]   wdata,
   output logic [15:0]   rdata
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("bufport_mem: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [7:0] bytes_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         bytes_q[{waddr, 1'b0}] <= wdata[7:0];
         bytes_q[{waddr, 1'b1}] <= wdata[15:8];
      end
   end

   assign rdata = {bytes_q[{waddr, 1'b1}], bytes_q[{waddr, 1'b0}]};
endmodule

// File: rtl/bufport_ctrl.sv
module bufport_ctrl
   import bufport_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_stb,
   input  logic [7:0]     cmd_code,
   input  logic           cnt_wr,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic           data_stb,
   input  logic           data_we,
   input  logic           cur_half,
   output logic           active,
   output logic           op_wr,
   output logic           op_asy,
   output logic           xfer_half,
   output logic [CNT_W:0] ptr,
   output logic           acc,
   output logic           eot,
   output logic           cmd_ok
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("bufport_ctrl: CNT_W must be at least 2");
      end
   endgenerate

   op_t            dec;
   logic [CNT_W:0] cnt_q, cnt_up, ptr_nx;

   assign dec    = decode_op(cmd_code);
   assign cmd_ok = cmd_stb && dec.valid;
   assign cnt_up = {1'b0, cnt_val} + (CNT_W+1)'(1);
   assign acc    = active && data_stb && !cmd_stb && (data_we == op_wr);
   assign ptr_nx = ptr + (CNT_W+1)'(2);
   assign eot    = acc && (ptr_nx == cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         active    <= 1'b0;
         op_wr     <= 1'b0;
         op_asy    <= 1'b0;
         xfer_half <= 1'b0;
         ptr       <= '0;
      end else begin
         if (cnt_wr) cnt_q <= {cnt_up[CNT_W:1], 1'b0};
         if (cmd_ok) begin
            active    <= (cnt_q != '0);
            op_wr     <= dec.wr;
            op_asy    <= dec.asy;
            xfer_half <= cur_half;
            ptr       <= '0;
         end else if (acc) begin
            ptr <= ptr_nx;
            if (eot) active <= 1'b0;
         end
      end
   end

   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (ptr == $past(ptr) + (CNT_W+1)'(2)));
   p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (ptr < cnt_q));
   p_cmd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ok |=> (ptr == '0));
endmodule

// File: rtl/bufport_pingpong.sv
module bufport_pingpong (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sof,
   input  logic [1:0] set_full,
   input  logic [1:0] drain_done,
   output logic       sel,
   output logic [1:0] full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel  <= 1'b0;
         full <= 2'b00;
      end else begin
         full <= (full | set_full) & ~drain_done;
         if (sof) sel <= (full == 2'b11) ? 1'b1 : ~sel;
      end
   end

   p_sof_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && full != 2'b11) |=> (sel != $past(sel)));
   p_both_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && full == 2'b11) |=> sel);
   p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_done[0] && !set_full[0]) |=> !full[0]);
   p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_full[1] && !drain_done[1]) |=> full[1]);
endmodule

// File: rtl/bufport_top.sv
module bufport_top
   import bufport_pkg::*;
#(
   parameter int ISO_DEPTH = 1024,
   parameter int ASY_DEPTH = 2048,
   parameter int CNT_W     = 16,
   localparam int ISO_AW   = $clog2(ISO_DEPTH),
   localparam int ASY_AW   = $clog2(ASY_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_stb,
   input  logic [7:0]       cmd_code,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             data_stb,
   input  logic             data_we,
   input  logic [15:0]      wdata,
   output logic [15:0]      rdata,
   input  logic             stat_clr_wr,
   input  logic [7:0]       stat_clr_data,
   input  logic             sof,
   input  logic [1:0]       drain_done,
   output logic             iso_sel,
   output logic [1:0]       iso_full,
   output logic             async_done,
   output logic [7:0]       int_status
);
   generate
      if (CNT_W <= ASY_AW || CNT_W <= ISO_AW) begin : g_bad_width
         $error("bufport_top: CNT_W must exceed the memory address width");
      end
   endgenerate

   logic           active, op_wr, op_asy, xfer_half, acc, eot, cmd_ok;
   logic [CNT_W:0] ptr;
   logic [15:0]    iso_rd, asy_rd;
   logic [1:0]     set_full;
   logic           eot_q;

   bufport_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
      .cnt_wr(cnt_wr), .cnt_val(cnt_val), .data_stb(data_stb),
      .data_we(data_we), .cur_half(iso_sel), .active(active),
      .op_wr(op_wr), .op_asy(op_asy), .xfer_half(xfer_half), .ptr(ptr),
      .acc(acc), .eot(eot), .cmd_ok(cmd_ok));

   bufport_mem #(.DEPTH(2*ISO_DEPTH)) u_iso_mem (
      .clk(clk), .we(acc && op_wr && !op_asy),
      .waddr({xfer_half, ptr[ISO_AW-1:1]}), .wdata(wdata), .rdata(iso_rd));

   bufport_mem #(.DEPTH(ASY_DEPTH)) u_asy_mem (
      .clk(clk), .we(acc && op_wr && op_asy),
      .waddr(ptr[ASY_AW-1:1]), .wdata(wdata), .rdata(asy_rd));

   assign set_full = (eot && op_wr && !op_asy) ? (xfer_half ? 2'b10 : 2'b01) : 2'b00;

   bufport_pingpong u_pp (
      .clk(clk), .rst_n(rst_n), .sof(sof), .set_full(set_full),
      .drain_done(drain_done), .sel(iso_sel), .full(iso_full));

   assign rdata = (acc && !op_wr) ? (op_asy ? asy_rd : iso_rd) : 16'h0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eot_q      <= 1'b0;
         async_done <= 1'b0;
      end else begin
         if (eot) eot_q <= 1'b1;
         else if (stat_clr_wr && stat_clr_data[EOT_BIT]) eot_q <= 1'b0;
         if (cmd_ok) async_done <= 1'b0;
         else if (eot && op_asy) async_done <= 1'b1;
      end
   end

   always_comb begin
      int_status          = 8'h00;
      int_status[EOT_BIT] = eot_q;
   end

   p_eot_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eot |=> int_status[EOT_BIT]);
   p_asy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ok |=> !async_done);
endmodule

// File: tb/bufport_top_tb.sv
`timescale 1ns/1ps
module bufport_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_stb = 0, cnt_wr = 0, data_stb = 0, data_we = 0, stat_clr_wr = 0, sof = 0;
   logic [7:0]  cmd_code = 0, stat_clr_data = 0;
   logic [15:0] cnt_val = 0, wdata = 0, rdata;
   logic [1:0]  drain_done = 0, iso_full;
   logic        iso_sel, async_done;
   logic [7:0]  int_status;

   int tests = 0, fails = 0;
   bit done = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   bufport_top u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
      .cnt_wr(cnt_wr), .cnt_val(cnt_val), .data_stb(data_stb),
      .data_we(data_we), .wdata(wdata), .rdata(rdata),
      .stat_clr_wr(stat_clr_wr), .stat_clr_data(stat_clr_data), .sof(sof),
      .drain_done(drain_done), .iso_sel(iso_sel), .iso_full(iso_full),
      .async_done(async_done), .int_status(int_status));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops expected read words as the port delivers them
   always @(negedge clk) begin
      if (data_stb && !data_we) begin
         if (exp_q.size() == 0) chk("scoreboard-empty", rdata, 16'hxxxx);
         else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic pulse_begin();
      @(posedge clk); #1;
   endtask
   task automatic pulse_end();
      @(posedge clk); #1;
      cmd_stb = 0; cnt_wr = 0; data_stb = 0; data_we = 0; stat_clr_wr = 0;
      sof = 0; drain_done = 0;
   endtask
   task automatic set_cnt(input logic [15:0] n);
      pulse_begin(); cnt_wr = 1; cnt_val = n; pulse_end();
   endtask
   task automatic cmd(input logic [7:0] c);
      pulse_begin(); cmd_stb = 1; cmd_code = c; pulse_end();
   endtask
   task automatic wr(input logic [15:0] d);
      pulse_begin(); data_stb = 1; data_we = 1; wdata = d; pulse_end();
   endtask
   task automatic rd(input logic [15:0] e, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      pulse_begin(); data_stb = 1; data_we = 0; pulse_end();
   endtask
   task automatic clr(input logic [7:0] m);
      pulse_begin(); stat_clr_wr = 1; stat_clr_data = m; pulse_end();
   endtask
   task automatic tick();
      pulse_begin(); sof = 1; pulse_end();
   endtask
   task automatic drain(input logic [1:0] m);
      pulse_begin(); drain_done = m; pulse_end();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R11 reset state
      chk("R11 iso_sel", {15'b0, iso_sel}, 16'h0);
      chk("R11 iso_full", {14'b0, iso_full}, 16'h0);
      chk("R11 async_done", {15'b0, async_done}, 16'h0);
      chk("R11 int_status", {8'b0, int_status}, 16'h0);
      rd(16'h0000, "R6 read before any command");

      // asynchronous write, 8 bytes
      set_cnt(16'd8); cmd(8'hC1);
      wr(16'h1111); wr(16'h2222); wr(16'h3333); wr(16'h4444);
      chk("R5 irq after eot", {15'b0, int_status[2]}, 16'h1);
      clr(8'h04);
      chk("R5 irq cleared", {15'b0, int_status[2]}, 16'h0);
      // odd count 5 rounds to 6 bytes
      set_cnt(16'd5); cmd(8'hC1);
      chk("R9 done cleared by cmd", {15'b0, async_done}, 16'h0);
      wr(16'hAAAA); wr(16'hBBBB);
      chk("R4 no eot before count", {15'b0, int_status[2]}, 16'h0);
      wr(16'hCCCC);
      chk("R4 eot at rounded count", {15'b0, int_status[2]}, 16'h1);
      chk("R9 async_done set", {15'b0, async_done}, 16'h1);
      wr(16'hDEAD);                          // after eot: ignored
      rd(16'h0000, "R6 read after eot");
      clr(8'h00);
      chk("R5 zero write keeps irq", {15'b0, int_status[2]}, 16'h1);
      clr(8'h04);

      // read back, stray write must not have landed at byte 6
      set_cnt(16'd8); cmd(8'h41);
      rd(16'hAAAA, "R2 word0"); rd(16'hBBBB, "R3 word1");
      rd(16'hCCCC, "R3 word2"); rd(16'h4444, "R6 stray write ignored");

      // pointer restart, unknown code, wrong direction
      cmd(8'h41);
      rd(16'hAAAA, "R10 first");
      cmd(8'h41);
      rd(16'hAAAA, "R10 restart");
      cmd(8'h55);
      rd(16'hBBBB, "R1 unknown code ignored");
      wr(16'h9999);
      rd(16'hCCCC, "R6 wrong direction ignored");
      rd(16'h4444, "R3 last");

      // isochronous ping-pong
      chk("R8 sel start", {15'b0, iso_sel}, 16'h0);
      set_cnt(16'd4); cmd(8'hC0);
      wr(16'h0101); wr(16'h0202);
      chk("R7 half0 full", {14'b0, iso_full}, 16'h1);
      tick();
      chk("R8 toggle to 1", {15'b0, iso_sel}, 16'h1);
      cmd(8'hC0);
      wr(16'h0303); wr(16'h0404);
      chk("R7 both full", {14'b0, iso_full}, 16'h3);
      tick();
      chk("R8 held at 1 when full", {15'b0, iso_sel}, 16'h1);
      tick();
      chk("R8 still held", {15'b0, iso_sel}, 16'h1);
      drain(2'b10);
      chk("R7 drain half1", {14'b0, iso_full}, 16'h1);
      tick();
      chk("R8 toggle to 0", {15'b0, iso_sel}, 16'h0);
      cmd(8'h40);
      rd(16'h0101, "R2 half0 w0"); rd(16'h0202, "R2 half0 w1");
      chk("R7 read does not fill", {14'b0, iso_full}, 16'h1);
      tick();
      cmd(8'h40);
      rd(16'h0303, "R8 half1 w0"); rd(16'h0404, "R8 half1 w1");
      drain(2'b01);
      chk("R7 drain half0", {14'b0, iso_full}, 16'h0);

      repeat (2) @(posedge clk);
      #1;
      if (exp_q.size() != 0) chk("scoreboard-leftover", 16'(exp_q.size()), 16'h0);
      finish_run();
   end
endmodule